// File: doc/BRIEF.md
# Truth-Table Bitwise Logic Unit

This block applies any one of the sixteen two-input Boolean functions, bit by bit, to a held operand register (the accumulator) and an external operand. The 4-bit function code is the truth table of the function itself. Each result bit is a 4-to-1 pick among the code bits, steered by the accumulator bit and the matching operand bit. No decoder sits between the code and the result.

The result is combinational. A load strobe writes it back into the accumulator on the next rising clock edge, so bit-manipulation sequences run in place: selective set, selective complement, selective clear, mask, field insert and compare-to-clear. The accumulator is filled from outside with the pass-operand code and a load. A zero flag reports an all-zero result. Arithmetic and shifts are out of scope.

Top module: `bitlogic_unit`

## Requirements
- R1: On a rising edge with `rst` high, the accumulator becomes all zeros.
- R2: Result bit i equals code bit 3 when (acc[i], opnd[i]) = (0,0), bit 2 for (0,1), bit 1 for (1,0) and bit 0 for (1,1).
- R3: Code 4'b0000 gives an all-zero result and code 4'b1111 gives an all-ones result, whatever the operands are.
- R4: Code 4'b0011 passes the accumulator, 4'b0101 passes the operand, 4'b1100 inverts the accumulator and 4'b1010 inverts the operand.
- R5: Code 4'b0001 is AND, 4'b0111 is OR, 4'b0110 is XOR, 4'b1110 is NAND, 4'b1000 is NOR and 4'b1001 is XNOR.
- R6: When `load` is high on a rising edge (and `rst` is low), the accumulator takes the result of that cycle.
- R7: When `load` is low on a rising edge (and `rst` is low), the accumulator keeps its value.
- R8: `zero` is high exactly when every result bit is 0.
- R9: With acc = 8'h0A and opnd = 8'h0C: OR (set) gives 8'h0E, XOR (complement) gives 8'h06, code 4'b0010 (acc AND NOT opnd, clear) gives 8'h02, and AND (mask) gives 8'h08.
- R10: Insert: acc = 8'h6A masked by AND with 8'h0F and loaded, then ORed with 8'h90 and loaded, leaves 8'h9A.
- R11: XOR with an operand equal to the accumulator gives an all-zero result with `zero` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd | input | WIDTH | Second operand (y) |
| func | input | 4 | Function code, equal to the truth table |
| load | input | 1 | Write the result into the accumulator |
| result | output | WIDTH | Combinational function of acc and opnd |
| acc | output | WIDTH | Accumulator register (x operand) |
| zero | output | 1 | High when the result is all zeros |

## Verification
The clocked properties assume that `func`, `opnd` and `load` are settled and known at each rising edge, because they compare the result with the fixed-code identities and the accumulator with the previous cycle's result. The stimulus changes every input only on falling edges, so this assumption holds. It drives no inputs during reset except idle values. It then walks all sixteen codes on an accumulator and operand pair that covers every bit combination, and follows this with load and hold sequences.

// File: rtl/bitlogic_pkg.sv
package bitlogic_pkg;
  localparam int FUNC_W = 4;
  typedef logic [FUNC_W-1:0] func_t;
  localparam func_t F_CLEAR = 4'b0000;
  localparam func_t F_ONES  = 4'b1111;
  localparam func_t F_PASSA = 4'b0011;
  localparam func_t F_PASSB = 4'b0101;
endpackage

// File: rtl/bitlogic_lane.sv
module bitlogic_lane
  import bitlogic_pkg::*;
(
  input  logic  x,
  input  logic  y,
  input  func_t func,
  output logic  f
);
  logic [1:0] sel;
  always_comb begin
    sel = {x, y};
    case (sel)
      2'b00:   f = func[3];
      2'b01:   f = func[2];
      2'b10:   f = func[1];
      default: f = func[0];
    endcase
  end
endmodule

// File: rtl/bitlogic_zero.sv
module bitlogic_zero #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] vec,
  output logic             is_zero
);
  assign is_zero = ~(|vec);
endmodule

// File: rtl/bitlogic_acc.sv
module bitlogic_acc #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  // R6
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && load) |=> (q == $past(d)));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !load) |=> $stable(q));
endmodule

// File: rtl/bitlogic_unit.sv
module bitlogic_unit
  import bitlogic_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opnd,
  input  logic [3:0]       func,
  input  logic             load,
  output logic [WIDTH-1:0] result,
  output logic [WIDTH-1:0] acc,
  output logic             zero
);
  localparam int MSB = WIDTH - 1;

  logic [MSB:0] lane_out;

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    bitlogic_lane u_lane (
      .x    (acc[i]),
      .y    (opnd[i]),
      .func (func),
      .f    (lane_out[i])
    );
  end

  assign result = lane_out;

  bitlogic_zero #(.WIDTH(WIDTH)) u_zero (
    .vec     (lane_out),
    .is_zero (zero)
  );

  bitlogic_acc #(.WIDTH(WIDTH)) u_acc (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .d    (lane_out),
    .q    (acc)
  );

  // R3
  clear_code_chk: assert property (@(posedge clk) disable iff (rst)
    (func == F_CLEAR) |-> (result == '0 && zero));
  // R3
  ones_code_chk: assert property (@(posedge clk) disable iff (rst)
    (func == F_ONES) |-> (result == '1 && !zero));
  // R4
  pass_a_chk: assert property (@(posedge clk) disable iff (rst)
    (func == F_PASSA) |-> (result == acc));
  // R4
  pass_b_chk: assert property (@(posedge clk) disable iff (rst)
    (func == F_PASSB) |-> (result == opnd));
endmodule

// File: tb/bitlogic_unit_tb.sv
module bitlogic_unit_tb;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [W-1:0] res;
    logic         zf;
    logic [W-1:0] accv;
    string        tag;
  } item_t;

  logic         clk = 0;
  logic         rst = 1;
  logic [W-1:0] opnd = '0;
  logic [3:0]   func = '0;
  logic         load = 0;
  logic [W-1:0] result, acc;
  logic         zero;

  int total = 0;
  int bad = 0;
  item_t sb[$];
  logic [W-1:0] model_acc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitlogic_unit #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .opnd(opnd), .func(func), .load(load),
    .result(result), .acc(acc), .zero(zero)
  );

  function automatic logic [W-1:0] expect_f(logic [3:0] f, logic [W-1:0] a, logic [W-1:0] b);
    return (~a & ~b & {W{f[3]}}) | (~a & b & {W{f[2]}}) |
           (a & ~b & {W{f[1]}}) | (a & b & {W{f[0]}});
  endfunction

  task automatic drive(input logic [W-1:0] b, input logic [3:0] f, input logic ld,
                       input string tag, input logic use_fixed = 0,
                       input logic [W-1:0] fixed_res = '0);
    item_t it;
    @(negedge clk);
    opnd = b; func = f; load = ld;
    it.res  = use_fixed ? fixed_res : expect_f(f, model_acc, b);
    it.zf   = (it.res == '0);
    it.accv = model_acc;
    it.tag  = tag;
    sb.push_back(it);
    if (ld) model_acc = it.res;
  endtask

  // monitor: compares after the design settles, away from edges
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      total += 3;
      if (result !== it.res) begin
        bad++; $display("FAIL %s result act=%h exp=%h", it.tag, result, it.res);
      end
      if (zero !== it.zf) begin
        bad++; $display("FAIL %s/R8 zero act=%b exp=%b", it.tag, zero, it.zf);
      end
      if (acc !== it.accv) begin
        bad++; $display("FAIL %s acc act=%h exp=%h", it.tag, acc, it.accv);
      end
    end
  end

  function automatic string code_tag(logic [3:0] f);
    case (f)
      4'b0000, 4'b1111: return "R3";
      4'b0011, 4'b0101, 4'b1010, 4'b1100: return "R4";
      4'b0001, 4'b0110, 4'b0111, 4'b1000, 4'b1001, 4'b1110: return "R5";
      default: return "R2";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state, acc zero after reset edges
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    drive(8'h00, 4'b0000, 0, "R1");
    // R1 again: load something, then reset clears it
    drive(8'hA5, 4'b0101, 1, "R6");
    @(negedge clk); rst = 1; load = 0;
    @(negedge clk); rst = 0; model_acc = '0;
    drive(8'h00, 4'b0011, 0, "R1", 1, 8'h00);

    // R9 selective operations on acc=0A, opnd=0C
    drive(8'h0A, 4'b0101, 1, "R6");
    drive(8'h0C, 4'b0111, 0, "R9", 1, 8'h0E);
    drive(8'h0C, 4'b0110, 0, "R9", 1, 8'h06);
    drive(8'h0C, 4'b0010, 0, "R9", 1, 8'h02);
    drive(8'h0C, 4'b0001, 0, "R9", 1, 8'h08);

    // R10 insert sequence
    drive(8'h6A, 4'b0101, 1, "R6");
    drive(8'h0F, 4'b0001, 1, "R10", 1, 8'h0A);
    drive(8'h90, 4'b0111, 1, "R10", 1, 8'h9A);
    drive(8'h00, 4'b0011, 0, "R10", 1, 8'h9A);

    // R11 compare-clear, R7 hold across idle cycles
    drive(8'h5C, 4'b0101, 1, "R6");
    drive(8'h5C, 4'b0110, 0, "R11", 1, 8'h00);
    drive(8'hFF, 4'b1111, 0, "R7");
    drive(8'h5C, 4'b0110, 0, "R7", 1, 8'h00);

    // R2..R5: every code with all four bit pairings (acc=CC, opnd=AA)
    drive(8'hCC, 4'b0101, 1, "R6");
    for (int c = 0; c < 16; c++) drive(8'hAA, c[3:0], 0, code_tag(c[3:0]));
    // R2 with a direct truth-table reading: code 0100 -> only (0,1) pairs high
    drive(8'hAA, 4'b0100, 0, "R2", 1, 8'h22);

    // R6: chained loads with varied codes and operands
    for (int k = 0; k < 24; k++) begin
      logic [W-1:0] b;
      logic [3:0] f;
      b = W'((k * 37 + 11) & 8'hFF);
      f = 4'((k * 7 + 3) & 4'hF);
      drive(b, f, k[0], "R6");
    end

    repeat (3) @(negedge clk);
    #(CLK_PERIOD/2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule